// File: doc/BRIEF.md
# Memory Error-Correction Scrubber Engine

This block masters a memory port and walks an address range of main memory in one of three operations chosen when a pass starts. Initialise writes a programmable fill pattern to every location without reading, so that each word afterwards holds valid check bits. Scrub reads every location and writes the corrected word back only when the read reported a correctable error. It runs periodically: from the top of the range it wraps back to the bottom until it is told to halt. Regenerate reads and rewrites every location once. This lets memory be re-encoded under a different check code, for example after a permanent device failure.

Configuration comes from the register file around the block as plain inputs: the low and high addresses, the operation code, the fill pattern, an idle gap between locations that caps the bandwidth, and a correctable-error threshold. A one-cycle start pulse latches them. Correctable errors are counted, and the counter is cleared by a one-cycle write-one pulse. The count raises an alert pulse when it reaches the threshold. An uncorrectable error stops the pass at once and latches the failing address in a sticky status with its own alert pulse. The error-correction codec and the memory controller sit outside this block.

Top module: `mem_scrub_engine`

## Requirements
- R1: After reset, busy, done, ue_flag, ce_irq, ue_irq and mem_req are 0 and ce_count is 0.
- R2: With cfg_mode code 0 (initialise), the pass issues only writes of cfg_pattern, one per address, ascending from cfg_lo to cfg_hi. It then ends with busy 0 and done 1, and memory outside the range is untouched.
- R3: With cfg_mode code 1 (scrub), each location is read once per sweep. A write-back of the returned data to the same address follows only when that read carried mem_ce; a clean read is followed by no write.
- R4: In scrub mode, after the location at cfg_hi the walk wraps to cfg_lo and continues. While halt is high, the pass ends after the current location completes, in any mode.
- R5: With cfg_mode code 2 (regenerate; code 3 acts the same), every location in the range is read and then rewritten with the data the read returned, in a single pass.
- R6: Each read response with mem_ce set (and mem_ue clear) raises ce_count by one in the following cycle. A cnt_clr pulse sets it to 0 and wins over a simultaneous increment.
- R7: ce_irq is a one-cycle pulse in the cycle in which ce_count becomes equal to a nonzero cfg_limit; a limit of 0 never raises it.
- R8: A read response with mem_ue ends the pass in the following cycle without any write. It sets ue_flag and ue_addr to the failing address and pulses ue_irq for one cycle. ue_flag stays set until the next accepted start.
- R9: After a location completes (its final write is granted, or its clean read returns) and the pass continues, mem_req stays low for exactly cfg_gap+1 cycles before the next location is requested.
- R10: A raised mem_req keeps mem_addr, mem_we and mem_wdata stable until mem_gnt, and only one read is outstanding at a time.
- R11: A go pulse while busy is ignored: the running pass keeps its latched configuration and sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted only while idle |
| halt | input | 1 | End the pass after the current location |
| cfg_mode | input | 2 | 0 initialise, 1 scrub, 2 or 3 regenerate |
| cfg_lo | input | AW | First address of the range |
| cfg_hi | input | AW | Last address of the range |
| cfg_pattern | input | DW | Fill word for initialise |
| cfg_gap | input | GW | Idle cycles added between locations |
| cfg_limit | input | CW | Correctable-error alert threshold, 0 disables |
| cnt_clr | input | 1 | Clears ce_count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Access address, also the current location |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DW | Read data, already corrected |
| mem_ce | input | 1 | Response had a correctable error |
| mem_ue | input | 1 | Response had an uncorrectable error |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass finished, cleared by start |
| ce_count | output | CW | Correctable errors counted |
| ce_irq | output | 1 | Threshold alert pulse |
| ue_flag | output | 1 | Sticky uncorrectable-error status |
| ue_irq | output | 1 | Uncorrectable-error alert pulse |
| ue_addr | output | AW | Address of the uncorrectable error |

## Verification
The assertions assume the memory side behaves: cfg_lo is never above cfg_hi, mem_rvalid comes only for a granted read and never sets mem_ce and mem_ue together, and mem_gnt is raised only against a live request. The bench's memory model grants after a random 0 to 2 cycle wait and answers each read after a random 1 to 3 cycles, and it never raises both error flags on one response. All ranges it programs have the low address at or below the high one. It changes cfg_* and pulses go mid-pass only to exercise R11; the design latches its configuration at start, so the assumptions still hold.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [1:0] {
    OP_INIT  = 2'd0,
    OP_SCRUB = 2'd1,
    OP_REGEN = 2'd2
  } scrub_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIX,
    ST_ADV,
    ST_GAP
  } scrub_st_e;
endpackage

// File: rtl/scrub_addr_walk.sv
module scrub_addr_walk #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= lo;
    else if (step) addr <= at_end ? lo : addr + 1'b1;
  end

  assign at_end = (addr == hi);
endmodule

// File: rtl/scrub_gap_timer.sv
module scrub_gap_timer #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [GW-1:0] val,
  input  logic          tick,
  output logic          last
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= GW'(1));
endmodule

// File: rtl/scrub_err_count.sv
module scrub_err_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          hit
);
  logic [CW-1:0] nxt;
  assign nxt = count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      hit   <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (clr) begin
        count <= '0;
      end else if (inc && count != '1) begin
        count <= nxt;
        hit   <= (limit != '0) && (nxt == limit);
      end
    end
  end
endmodule

// File: rtl/mem_scrub_engine.sv
module mem_scrub_engine
  import scrub_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int GW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          halt,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic [DW-1:0] cfg_pattern,
  input  logic [GW-1:0] cfg_gap,
  input  logic [CW-1:0] cfg_limit,
  input  logic          cnt_clr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ce,
  input  logic          mem_ue,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] ce_count,
  output logic          ce_irq,
  output logic          ue_flag,
  output logic          ue_irq,
  output logic [AW-1:0] ue_addr
);
  scrub_st_e     st;
  logic [1:0]    mode_q;
  logic [AW-1:0] lo_q, hi_q, cur;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] limit_q;
  logic [DW-1:0] wbuf;
  logic          start, at_end, finish, gap_last, ce_inc, rd_ret;

  assign start  = go && (st == ST_IDLE);
  assign finish = halt || (at_end && mode_q != OP_SCRUB);
  assign rd_ret = (st == ST_WAIT) && mem_rvalid;
  assign ce_inc = rd_ret && mem_ce && !mem_ue;

  // Address walker: loads the low bound at start, wraps at the high bound.
  scrub_addr_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst(rst),
    .load(start),
    .step((st == ST_ADV) && !finish),
    .lo(start ? cfg_lo : lo_q),
    .hi(hi_q),
    .addr(cur),
    .at_end(at_end)
  );

  // Idle-gap timer between locations (bandwidth limit).
  scrub_gap_timer #(.GW(GW)) u_gap (
    .clk(clk), .rst(rst),
    .load(st == ST_ADV),
    .val(gap_q),
    .tick(st == ST_GAP),
    .last(gap_last)
  );

  // Correctable-error counter with threshold alert.
  scrub_err_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst),
    .clr(cnt_clr),
    .inc(ce_inc),
    .limit(limit_q),
    .count(ce_count),
    .hit(ce_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mode_q  <= 2'd0;
      lo_q    <= '0;
      hi_q    <= '0;
      gap_q   <= '0;
      limit_q <= '0;
      wbuf    <= '0;
      done    <= 1'b0;
      ue_flag <= 1'b0;
      ue_irq  <= 1'b0;
      ue_addr <= '0;
    end else begin
      ue_irq <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st      <= ST_ISSUE;
          mode_q  <= (cfg_mode == 2'd3) ? 2'd2 : cfg_mode;
          lo_q    <= cfg_lo;
          hi_q    <= cfg_hi;
          gap_q   <= cfg_gap;
          limit_q <= cfg_limit;
          wbuf    <= cfg_pattern;
          done    <= 1'b0;
          ue_flag <= 1'b0;
        end
        ST_ISSUE: if (mem_gnt) st <= (mode_q == OP_INIT) ? ST_ADV : ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          wbuf <= mem_rdata;
          if (mem_ue) begin
            st      <= ST_IDLE;
            done    <= 1'b1;
            ue_flag <= 1'b1;
            ue_irq  <= 1'b1;
            ue_addr <= cur;
          end else if (mem_ce || mode_q == OP_REGEN) begin
            st <= ST_FIX;
          end else begin
            st <= ST_ADV;
          end
        end
        ST_FIX: if (mem_gnt) st <= ST_ADV;
        ST_ADV: begin
          if (finish) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st <= (gap_q == '0) ? ST_ISSUE : ST_GAP;
          end
        end
        ST_GAP: if (gap_last) st <= ST_ISSUE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_ISSUE) || (st == ST_FIX);
  assign mem_we    = (st == ST_FIX) || ((st == ST_ISSUE) && (mode_q == OP_INIT));
  assign mem_addr  = cur;
  assign mem_wdata = wbuf;
endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rvalid,
  input logic [CW-1:0] ce_count,
  input logic          cnt_clr,
  input logic          ue_irq,
  input logic          ue_flag,
  input logic [1:0]    mode_q,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  assert_init_writes_only_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == 2'd0 && mem_req) |-> mem_we);

  assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr >= lo_q && mem_addr <= hi_q));

  assert_count_no_drop_R6: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> ce_count >= $past(ce_count));

  assert_ue_ends_pass_R8: assert property (@(posedge clk) disable iff (rst)
    ue_irq |-> (ue_flag && done && !busy));

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |=> (busy && !done && !ue_flag));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_no_resp_with_req_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> !mem_req);
endmodule

bind mem_scrub_engine scrub_checker #(.AW(AW), .DW(DW), .CW(CW)) u_scrub_chk (
  .clk(clk), .rst(rst), .go(go), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
  .ce_count(ce_count), .cnt_clr(cnt_clr), .ue_irq(ue_irq), .ue_flag(ue_flag),
  .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/mem_scrub_engine_bench.sv
module mem_scrub_engine_bench;
  localparam int AW = 16, DW = 32, GW = 8, CW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic go = 1'b0, halt = 1'b0, cnt_clr = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [DW-1:0] cfg_pattern = '0;
  logic [GW-1:0] cfg_gap = '0;
  logic [CW-1:0] cfg_limit = '0;
  logic mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_ce = 1'b0, mem_ue = 1'b0;
  logic [AW-1:0] mem_addr, ue_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic busy, done, ce_irq, ue_flag, ue_irq;
  logic [CW-1:0] ce_count;

  always #2 clk = ~clk;

  mem_scrub_engine #(.AW(AW), .DW(DW), .GW(GW), .CW(CW)) u_mem_scrub_engine (
    .clk(clk), .rst(rst), .go(go), .halt(halt), .cfg_mode(cfg_mode),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_pattern(cfg_pattern), .cfg_gap(cfg_gap),
    .cfg_limit(cfg_limit), .cnt_clr(cnt_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_ce(mem_ce), .mem_ue(mem_ue),
    .busy(busy), .done(done), .ce_count(ce_count), .ce_irq(ce_irq),
    .ue_flag(ue_flag), .ue_irq(ue_irq), .ue_addr(ue_addr)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Bench memory: data plus injected error kind (0 none, 1 correctable, 2 uncorrectable)
  logic [DW-1:0] mem [0:255];
  int ek [0:255];

  // Reference model state
  int m_mode, m_lo, m_hi, m_gap, m_limit;
  logic [DW-1:0] m_pat;
  bit m_run = 0, e_wb = 0, e_ceirq = 0, e_ueirq = 0, end_ue = 0, g_on = 0, halt_arm = 0;
  int e_addr, e_cnt = 0, end_cnt = 0, ue_at, g_low, gd = 0, rw = -1, r_addr;
  int wraps, wr_cnt, ceirq_seen;
  logic [DW-1:0] e_wbd;

  task automatic complete_loc();
    if (halt || (e_addr == m_hi && m_mode != 1)) begin
      end_cnt = 2; end_ue = 0;
    end else begin
      if (e_addr == m_hi) begin e_addr = m_lo; wraps++; end
      else e_addr++;
      g_on = 1; g_low = 0;
    end
  endtask

  always @(negedge clk) begin
    int n_cnt;
    if (rst) begin
      e_cnt = 0; rw = -1; gd = 0;
      mem_gnt <= 1'b0; mem_rvalid <= 1'b0; mem_ce <= 1'b0; mem_ue <= 1'b0;
    end else begin
      // Every-cycle comparisons
      chk(ce_count == CW'(e_cnt), "R6 ce_count", ce_count, e_cnt);
      chk(ce_irq == e_ceirq, "R7 ce_irq", ce_irq, e_ceirq);
      chk(ue_irq == e_ueirq, "R8 ue_irq", ue_irq, e_ueirq);
      if (ce_irq) ceirq_seen++;
      if (g_on) begin
        if (mem_req) begin
          chk(g_low == m_gap + 1, "R9 idle cycles between locations", g_low, m_gap + 1);
          g_on = 0;
        end else g_low++;
      end
      if (end_cnt > 0) begin
        end_cnt--;
        if (end_cnt == 0) begin
          chk(!busy, "R2 busy low at pass end", busy, 0);
          chk(done, "R2 done at pass end", done, 1);
          if (end_ue) begin
            chk(ue_flag, "R8 ue_flag", ue_flag, 1);
            chk(ue_addr == AW'(ue_at), "R8 ue_addr", ue_addr, ue_at);
          end
          m_run = 0;
        end
      end
      n_cnt = e_cnt; e_ceirq = 0; e_ueirq = 0;
      // Start (ignored while busy: R11)
      if (go && !busy) begin
        m_mode = (cfg_mode == 2'd3) ? 2 : int'(cfg_mode);
        m_lo = int'(cfg_lo); m_hi = int'(cfg_hi); m_gap = int'(cfg_gap);
        m_limit = int'(cfg_limit); m_pat = cfg_pattern;
        m_run = 1; e_addr = m_lo; e_wb = 0; wraps = 0; wr_cnt = 0;
      end
      // Read response
      mem_rvalid <= 1'b0; mem_ce <= 1'b0; mem_ue <= 1'b0;
      if (rw == 0) begin
        mem_rvalid <= 1'b1; mem_rdata <= mem[r_addr];
        mem_ce <= (ek[r_addr] == 1); mem_ue <= (ek[r_addr] == 2);
        if (ek[r_addr] == 2) begin
          end_cnt = 1; end_ue = 1; ue_at = r_addr; e_ueirq = 1;
        end else if (ek[r_addr] == 1) begin
          if (n_cnt < 65535) n_cnt++;
          e_ceirq = (m_limit != 0) && (n_cnt == m_limit);
          e_wb = 1; e_wbd = mem[r_addr];
        end else if (m_mode == 2) begin
          e_wb = 1; e_wbd = mem[r_addr];
        end else complete_loc();
        rw = -1;
      end else if (rw > 0) rw--;
      if (cnt_clr) begin n_cnt = 0; e_ceirq = 0; end
      e_cnt = n_cnt;
      // Grant and transaction check
      mem_gnt <= 1'b0;
      if (mem_req) begin
        if (gd == 0) begin
          mem_gnt <= 1'b1;
          gd = int'($urandom_range(0, 2));
          if (!mem_we) begin
            chk(m_mode != 0 && !e_wb, "R3 read only when expected", mem_we, 1);
            chk(int'(mem_addr) == e_addr, "R3 read address", mem_addr, e_addr);
            r_addr = int'(mem_addr[7:0]);
            rw = int'($urandom_range(0, 2));
            if (halt_arm && wraps >= 1) halt <= 1'b1;
          end else begin
            chk(int'(mem_addr) == e_addr, "R2 write address", mem_addr, e_addr);
            if (e_wb) chk(mem_wdata == e_wbd, "R5 write-back data", mem_wdata, e_wbd);
            else begin
              chk(m_mode == 0, "R3 no write without error", m_mode, 0);
              chk(mem_wdata == m_pat, "R2 fill pattern", mem_wdata, m_pat);
            end
            mem[mem_addr[7:0]] = mem_wdata; ek[mem_addr[7:0]] = 0;
            e_wb = 0; wr_cnt++;
            complete_loc();
          end
        end else gd--;
      end
    end
  end

  task automatic run_pass(input int mode, input int lo, input int hi,
                          input logic [DW-1:0] pat, input int gap, input int lim);
    @(posedge clk); #1;
    cfg_mode = 2'(mode); cfg_lo = AW'(lo); cfg_hi = AW'(hi);
    cfg_pattern = pat; cfg_gap = GW'(gap); cfg_limit = CW'(lim); go = 1'b1;
    @(posedge clk); #1; go = 1'b0;
  endtask

  task automatic wait_end();
    while (m_run) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 32'hC000_0000 | i; ek[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset busy/done/req", {busy, done, mem_req}, 0);
    chk(ce_count == 0 && !ue_flag && !ce_irq && !ue_irq, "R1 reset counters/flags", ce_count, 0);
    @(posedge clk); #1; rst = 1'b0;

    // Initialise 4..11, no gap
    run_pass(0, 4, 11, 32'hA5A5_0F0F, 0, 0); wait_end();
    for (int a = 4; a <= 11; a++) chk(mem[a] == 32'hA5A5_0F0F, "R2 filled word", mem[a], 32'hA5A5_0F0F);
    chk(mem[3] == 32'hC000_0003, "R2 below range untouched", mem[3], 32'hC000_0003);
    chk(mem[12] == 32'hC000_000C, "R2 above range untouched", mem[12], 32'hC000_000C);

    // Initialise 20..27 with a gap of 3
    run_pass(0, 20, 27, 32'h0000_1234, 3, 0); wait_end();
    chk(mem[27] == 32'h1234, "R9 gapped init completed", mem[27], 32'h1234);

    // Single-location range
    run_pass(0, 40, 40, 32'h0BAD_F00D, 0, 0); wait_end();
    chk(mem[40] == 32'h0BAD_F00D && mem[41] == 32'hC000_0029, "R2 single location", mem[40], 32'h0BAD_F00D);

    // Periodic scrub with two correctable errors, threshold 2, halt after wrap
    ek[5] = 1; ek[9] = 1; halt_arm = 1; ceirq_seen = 0;
    run_pass(1, 4, 11, '0, 1, 2); wait_end();
    chk(wraps >= 1, "R4 scrub wrapped", wraps, 1);
    chk(ce_count == 2, "R6 two corrections counted", ce_count, 2);
    chk(ceirq_seen == 1, "R7 single threshold alert", ceirq_seen, 1);
    chk(wr_cnt == 2, "R3 write-backs only for errors", wr_cnt, 2);
    halt_arm = 0; halt = 1'b0;

    // Clear the counter while idle
    @(posedge clk); #1; cnt_clr = 1'b1; @(posedge clk); #1; cnt_clr = 1'b0;
    @(negedge clk);
    chk(ce_count == 0, "R6 cleared by cnt_clr", ce_count, 0);

    // Regenerate 20..27, one correctable error, stray go mid-pass
    ek[22] = 1; ceirq_seen = 0;
    run_pass(2, 20, 27, '0, 0, 0);
    repeat (6) @(posedge clk); #1;
    cfg_mode = 2'd0; cfg_lo = AW'(60); cfg_hi = AW'(63); go = 1'b1;
    @(posedge clk); #1; go = 1'b0;
    wait_end();
    chk(wr_cnt == 8, "R5 every location rewritten", wr_cnt, 8);
    chk(mem[60] == 32'hC000_003C, "R11 go while busy ignored", mem[60], 32'hC000_003C);
    chk(ce_count == 1 && ceirq_seen == 0, "R7 limit 0 never alerts", ceirq_seen, 0);

    // Scrub with a correctable then an uncorrectable error
    ek[6] = 1; ek[7] = 2;
    run_pass(1, 4, 11, '0, 0, 0); wait_end();
    chk(ue_flag && ue_addr == 7, "R8 stop at failing address", ue_addr, 7);
    chk(wr_cnt == 1, "R8 no write after uncorrectable", wr_cnt, 1);
    chk(!busy, "R8 pass stopped", busy, 0);

    // Next start clears the sticky flag
    run_pass(0, 50, 51, 32'h5555_AAAA, 0, 0); wait_end();
    chk(!ue_flag && done, "R8 ue_flag cleared by start", ue_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule